// File: doc/BRIEF.md
# Photodetector Quench-Reset Sequencing Controller

This block is the digital sequencer for one avalanche photodetector channel. A discriminator reports an avalanche on a single detection input. The controller then takes the channel through four phases: listening, sense, quench and recharge. It drives the enable of the sensing amplifier and the complement of that enable, the quench-switch and reset-switch drives, a one-cycle timing strobe for the external time measurement, and a photon-detected pulse of fixed length. Every duration is a count of clock cycles.

Two software-loaded length inputs set how long the quench phase and the recharge phase last. The two lengths are independent. The quench length is sampled as the quench phase starts, and the recharge length is sampled as the quench phase ends. A gate input keeps the channel blind while the controller is listening. A sequence that is already running when the gate rises still runs to its end. The amplifier stays disconnected from the moment the quench switch closes until the cycle after the reset switch opens.

Top module: `photon_phase_seq`

## Requirements
- R1: On the asynchronous active-low reset, whether idle or in the middle of a sequence, the controller returns to listening. With the gate low, ampEn=1, ampEnN=0, and quenchOn, resetOn, photonPulse and timingStrobe are all 0.
- R2: When detIn is high at a clock edge while listening with gateIn low, timingStrobe is high for exactly the one cycle after that edge. The amplifier stays enabled during that cycle.
- R3: In the cycle after the strobe, quenchOn goes high, ampEn goes to 0 and ampEnN to 1. photonPulse is high for exactly PULSE_CYC cycles starting in that same cycle.
- R4: quenchOn stays high for quenchLen cycles. A value of 0 gives one cycle.
- R5: resetOn rises in the first cycle after quenchOn falls and stays high for resetLen cycles, counted independently of quenchLen. A value of 0 gives one cycle.
- R6: quenchOn and resetOn are never high in the same cycle.
- R7: ampEn stays 0 for the whole quench and recharge span and returns to 1 in the cycle after resetOn falls. ampEnN is the complement of ampEn in every cycle.
- R8: detIn pulses that arrive while a sequence is running are ignored. They give no second strobe and do not lengthen any phase.
- R9: While gateIn is high and the controller is listening, ampEn is 0 and detections are ignored. A detection held high across the falling edge of the gate is accepted at the first clock edge with the gate low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| detIn | input | 1 | Discriminator detection level |
| gateIn | input | 1 | High keeps the channel blind while listening |
| quenchLen | input | LEN_W | Quench length in cycles (0 means 1) |
| resetLen | input | LEN_W | Recharge length in cycles (0 means 1) |
| ampEn | output | 1 | Sensing amplifier enable |
| ampEnN | output | 1 | Complement of ampEn |
| quenchOn | output | 1 | Quench switch drive |
| resetOn | output | 1 | Reset switch drive |
| photonPulse | output | 1 | Photon-detected pulse, PULSE_CYC cycles long |
| timingStrobe | output | 1 | One-cycle timing event |

## Verification
The hardest case to reach from the ports is a detection that overlaps a running sequence. The bench holds detIn high from the first edge well into the recharge phase, then checks that only one strobe appears and that both phase lengths are unchanged. The other hard case is the hand-over at the falling edge of the gate. The bench keeps detIn high while the gate is up, then lowers the gate and expects the strobe one edge later. A table of length pairs includes zero values to cover the one-cycle minimum. A reset applied during quench checks the return to listening.

// File: rtl/photon_phase_pkg.sv
package photon_phase_pkg;

  typedef enum logic [1:0] {
    PH_LISTEN = 2'd0,
    PH_SENSE  = 2'd1,
    PH_QUENCH = 2'd2,
    PH_RECHG  = 2'd3
  } phase_e;

  typedef struct packed {
    logic loadQuench;
    logic loadRecharge;
    logic countDown;
    logic startPulse;
  } seq_ctrl_t;

endpackage

// File: rtl/photon_phase_timer.sv
module photon_phase_timer
  import photon_phase_pkg::*;
#(
  parameter int LEN_W     = 8,
  parameter int PULSE_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seq_ctrl_t        ctrl,
  input  logic [LEN_W-1:0] quenchLen,
  input  logic [LEN_W-1:0] resetLen,
  output logic             phaseDone,
  output logic             photonPulse
);

  localparam int PULSE_W = $clog2(PULSE_CYC + 1);

  logic [LEN_W-1:0]   phaseCnt;
  logic [PULSE_W-1:0] pulseCnt;

  function automatic logic [LEN_W-1:0] atLeastOne(input logic [LEN_W-1:0] v);
    return (v == '0) ? LEN_W'(1) : v;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (ctrl.loadQuench) begin
      phaseCnt <= atLeastOne(quenchLen);
    end else if (ctrl.loadRecharge) begin
      phaseCnt <= atLeastOne(resetLen);
    end else if (ctrl.countDown && phaseCnt > LEN_W'(1)) begin
      phaseCnt <= phaseCnt - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (ctrl.startPulse) begin
      pulseCnt <= PULSE_W'(PULSE_CYC);
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - PULSE_W'(1);
    end
  end

  assign phaseDone   = (phaseCnt == LEN_W'(1));
  assign photonPulse = (pulseCnt != '0);

  // R4
  load_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadQuench || ctrl.loadRecharge) |=> (phaseCnt != '0));

  // R3
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.startPulse |=> photonPulse);

endmodule

// File: rtl/photon_phase_fsm.sv
module photon_phase_fsm
  import photon_phase_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      detIn,
  input  logic      gateIn,
  input  logic      phaseDone,
  input  logic      photonPulse,
  output seq_ctrl_t ctrl,
  output logic      ampEn,
  output logic      ampEnN,
  output logic      quenchOn,
  output logic      resetOn,
  output logic      timingStrobe
);

  phase_e phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_LISTEN;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    ctrl      = '0;
    unique case (phase)
      PH_LISTEN: if (detIn && !gateIn) phaseNext = PH_SENSE;
      PH_SENSE: begin
        phaseNext       = PH_QUENCH;
        ctrl.loadQuench = 1'b1;
        ctrl.startPulse = 1'b1;
      end
      PH_QUENCH: begin
        ctrl.countDown = 1'b1;
        if (phaseDone) begin
          phaseNext         = PH_RECHG;
          ctrl.loadRecharge = 1'b1;
        end
      end
      PH_RECHG: begin
        ctrl.countDown = 1'b1;
        if (phaseDone) phaseNext = PH_LISTEN;
      end
      default: phaseNext = PH_LISTEN;
    endcase
  end

  assign timingStrobe = (phase == PH_SENSE);
  assign quenchOn     = (phase == PH_QUENCH);
  assign resetOn      = (phase == PH_RECHG);
  assign ampEn        = (phase == PH_SENSE) || (phase == PH_LISTEN && !gateIn);
  assign ampEnN       = !ampEn;

  // R8
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    timingStrobe |=> !timingStrobe);

  // R3
  strobe_to_quench_chk: assert property (@(posedge clk) disable iff (!rstN)
    timingStrobe |=> (quenchOn && photonPulse && !ampEn));

  // R5
  quench_handoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(quenchOn) |-> resetOn);

  // R7
  reset_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetOn) |-> (!quenchOn && (ampEn == !gateIn)));

  // R9
  gate_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gateIn && phase == PH_LISTEN) |=> !timingStrobe);

endmodule

// File: rtl/photon_phase_seq.sv
module photon_phase_seq
  import photon_phase_pkg::*;
#(
  parameter int LEN_W     = 8,
  parameter int PULSE_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             detIn,
  input  logic             gateIn,
  input  logic [LEN_W-1:0] quenchLen,
  input  logic [LEN_W-1:0] resetLen,
  output logic             ampEn,
  output logic             ampEnN,
  output logic             quenchOn,
  output logic             resetOn,
  output logic             photonPulse,
  output logic             timingStrobe
);

  seq_ctrl_t ctrl;
  logic      phaseDone;

  photon_phase_fsm u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .detIn        (detIn),
    .gateIn       (gateIn),
    .phaseDone    (phaseDone),
    .photonPulse  (photonPulse),
    .ctrl         (ctrl),
    .ampEn        (ampEn),
    .ampEnN       (ampEnN),
    .quenchOn     (quenchOn),
    .resetOn      (resetOn),
    .timingStrobe (timingStrobe)
  );

  photon_phase_timer #(
    .LEN_W     (LEN_W),
    .PULSE_CYC (PULSE_CYC)
  ) u_timer (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .quenchLen   (quenchLen),
    .resetLen    (resetLen),
    .phaseDone   (phaseDone),
    .photonPulse (photonPulse)
  );

endmodule

// File: tb/photon_phase_seq_tb.sv
module photon_phase_seq_tb;

  localparam int LEN_W = 8;
  localparam int PULSE = 2;
  localparam int WIN   = 30;

  // fields: quenchLen, resetLen, gate, expQuench, expReset, expStrobes
  localparam logic [47:0] VEC [6] = '{
    {8'd3, 8'd4, 8'd0, 8'd3, 8'd4, 8'd1},
    {8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd1},
    {8'd1, 8'd5, 8'd0, 8'd1, 8'd5, 8'd1},
    {8'd6, 8'd1, 8'd0, 8'd6, 8'd1, 8'd1},
    {8'd2, 8'd2, 8'd1, 8'd0, 8'd0, 8'd0},
    {8'd0, 8'd3, 8'd0, 8'd1, 8'd3, 8'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic detIn = 1'b0;
  logic gateIn = 1'b0;
  logic [LEN_W-1:0] quenchLen = '0;
  logic [LEN_W-1:0] resetLen = '0;
  logic ampEn, ampEnN, quenchOn, resetOn, photonPulse, timingStrobe;

  int nChecks = 0;
  int nFail = 0;

  photon_phase_seq #(.LEN_W(LEN_W), .PULSE_CYC(PULSE)) u_dut (
    .clk(clk), .rstN(rstN), .detIn(detIn), .gateIn(gateIn),
    .quenchLen(quenchLen), .resetLen(resetLen),
    .ampEn(ampEn), .ampEnN(ampEnN), .quenchOn(quenchOn), .resetOn(resetOn),
    .photonPulse(photonPulse), .timingStrobe(timingStrobe)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    check({req, " ampEn"}, int'(ampEn), 1);
    check({req, " ampEnN"}, int'(ampEnN), 0);
    check({req, " quenchOn"}, int'(quenchOn), 0);
    check({req, " resetOn"}, int'(resetOn), 0);
    check({req, " photonPulse"}, int'(photonPulse), 0);
    check({req, " timingStrobe"}, int'(timingStrobe), 0);
  endtask

  // called right after a negedge; detIn high for the first d edges
  task automatic runSeq(input int q, input int r, input int g, input int d,
                        input int eQ, input int eR, input int eS);
    int nS = 0, nQ = 0, nR = 0, nP = 0, nOff = 0, nBoth = 0, nBad = 0;
    int fS = -1, fQ = -1, fR = -1;
    quenchLen = LEN_W'(q);
    resetLen  = LEN_W'(r);
    gateIn    = g[0];
    detIn     = 1'b1;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      detIn = (i + 1 < d);
      if (timingStrobe) begin nS++; if (fS < 0) fS = i; end
      if (quenchOn) begin nQ++; if (fQ < 0) fQ = i; end
      if (resetOn) begin nR++; if (fR < 0) fR = i; end
      if (photonPulse) nP++;
      if (!ampEn) nOff++;
      if (quenchOn && resetOn) nBoth++;
      if (ampEnN == ampEn) nBad++;
    end
    check("R2/R8 strobe count", nS, eS);
    check("R4 quench cycles", nQ, eQ);
    check("R5 reset cycles", nR, eR);
    check("R6 overlap cycles", nBoth, 0);
    check("R7 complement errors", nBad, 0);
    check("R7/R9 amp-off cycles", nOff, g ? WIN : eQ + eR);
    check("R3 pulse cycles", nP, g ? 0 : PULSE);
    if (eS != 0) begin
      check("R2 strobe cycle", fS, 0);
      check("R3 quench start", fQ, 1);
      check("R5 reset start", fR, 1 + eQ);
    end
    gateIn = 1'b0;
    #1;
    check("R7 amp re-enabled", int'(ampEn), 1);
  endtask

  initial begin
    #(200000 * 20);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkIdle("R1 reset state");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 after release");

    for (int v = 0; v < 6; v++) begin
      runSeq(int'(VEC[v][47:40]), int'(VEC[v][39:32]), int'(VEC[v][31:24]), 1,
             int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]));
    end

    // R8: detIn held high well into recharge
    runSeq(5, 5, 0, 8, 5, 5, 1);

    // R9: gate high with detIn high, then release
    gateIn = 1'b1;
    detIn  = 1'b1;
    quenchLen = 8'd2;
    resetLen  = 8'd2;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 gated strobe", int'(timingStrobe), 0);
      check("R9 gated amp", int'(ampEn), 0);
    end
    gateIn = 1'b0;
    @(negedge clk);
    detIn = 1'b0;
    check("R9 strobe after gate release", int'(timingStrobe), 1);
    repeat (10) @(negedge clk);
    checkIdle("R9 back to idle");

    // R1: reset applied during quench
    quenchLen = 8'd6;
    detIn = 1'b1;
    @(negedge clk);
    detIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 in quench before reset", int'(quenchOn), 1);
    rstN = 1'b0;
    #1;
    checkIdle("R1 mid-sequence reset");
    @(negedge clk);
    rstN = 1'b1;
    repeat (8) @(negedge clk);
    checkIdle("R1 stays idle");

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule